// File: doc/BRIEF.md
# Data Access Translation and Protection Checker

This block takes one data access request per cycle and decides its outcome. The outcome is either a physical address, with a flag saying whether the access may be cached, or a fault code with a set of memory-status flags. The inputs are the virtual address, the access size, the direction of the access, the request qualifiers, the processor mode state and the result of a lookup in an external translation buffer.

The checks run in a fixed order, and the first one that fails decides the fault:

1. alignment;
2. physical pass-through;
3. canonical address form;
4. the kernel-only direct-mapped window;
5. translation miss;
6. per-mode read/write enables;
7. fault-on-read and fault-on-write;
8. physical-range and cacheability rules on the resulting address.

Every result is registered. It appears one cycle after the request. Three wrapping counters record translated hits, misses and protection violations.

The translation storage is not part of this block. The caller presents the hit flag, the page frame number and the permission bits for the requested address in the same cycle as the request.

Top module: `dxlate_check`

## Requirements

Encodings used below:
- Fault codes on `rsp_fault`: 0 none, 1 alignment, 2 page, 3 access violation, 4 miss, 5 double miss, 6 machine check, 7 unimplemented.
- Status bits on `rsp_stat`: bit0 write, bit1 bad address, bit2 access violation, bit3 miss, bit4 fault-on-read, bit5 fault-on-write.
- Modes: 0 kernel, 1 executive, 2 supervisor, 3 user. Enable bit n of a permission mask belongs to mode n.
- `req_size` is log2 of the byte count.
- Pages are 8 KiB.

- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise. `rsp_pa` reads zero whenever a fault is reported. After reset, `rsp_valid` and all three counters are zero.
- R2: If any address bit below 2^`req_size` is set, the result is fault 1 with only status bit0 equal to `req_write`. This check overrides every other check.
- R3: With `pc_lo` high, the effective mode for permission checks is `alt_mode` when `req_alt` is set, and kernel otherwise. With `pc_lo` low, it is `cur_mode`.
- R4: With `req_phys` set, the address is taken as physical unchanged. The canonical check and the translation inputs have no effect.
- R5: If address bits 63:43 are neither all zeros nor all ones, the result is fault 2 with status bits 1 and 2 set, and bit0 equal to `req_write`.
- R6: An address with bits 47:41 equal to 0x7E is direct-mapped. Its privilege check uses `cur_mode`, not the effective mode. Outside kernel mode the result is fault 3 with status bit2 and the write bit. In kernel mode the physical address is address bits 43:0, with bits 43:40 set to ones if bit 40 is set and cleared otherwise.
- R7: A translation miss gives fault 5 when `req_ptacc` is set and fault 4 otherwise. Status bit3 is set, and bit0 equals `req_write`.
- R8: On a hit, the physical address is the page frame number followed by address bits 12:0.
- R9: A store whose write-enable bit for the effective mode is clear gives fault 2 with status bits 0 and 2, plus bit5 if `tlb_fow` is set. A permitted store with `tlb_fow` set gives fault 2 with status bits 0 and 5 only.
- R10: A load whose read-enable bit for the effective mode is clear gives fault 3 with status bit2, plus bit4 if `tlb_for` is set. A permitted load with `tlb_for` set gives fault 2 with status bit4 only.
- R11: A physical address with any bit at position 44 or above gives fault 6 with zero status.
- R12: If physical address bits 43:40 equal 1010, the result is fault 7. Otherwise, if bit 43 is set, `rsp_uncached` is set and bits 42:35 are cleared.
- R13: `hit_cnt` counts translated accesses that pass the permission and fault-on checks. `miss_cnt` counts faults 4 and 5. `viol_cnt` counts faults 2 and 3. Each counter wraps.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | log2 of access size in bytes |
| req_write | input | 1 | 1 for store, 0 for load |
| req_phys | input | 1 | Address is already physical |
| req_alt | input | 1 | Use alternate mode when `pc_lo` is set |
| req_ptacc | input | 1 | Access is a page-table walk access |
| pc_lo | input | 1 | Bit 0 of the program counter |
| cur_mode | input | 2 | Current processor mode |
| alt_mode | input | 2 | Alternate processor mode |
| tlb_hit | input | 1 | External lookup found a matching entry |
| tlb_ppn | input | 31 | Page frame number of the matching entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_for | input | 1 | Entry faults on read |
| tlb_fow | input | 1 | Entry faults on write |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 44 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | Fault code |
| rsp_stat | output | 6 | Memory-status flags |
| hit_cnt | output | 16 | Translated hit count |
| miss_cnt | output | 16 | Miss count |
| viol_cnt | output | 16 | Violation count |

## Verification

The hardest outcomes to reach are those where two rules interact:
- A direct-mapped address with bit 40 set first gets its top nibble forced to ones. That makes it uncacheable, and the cacheability rule then clears bit 40 again.
- The direct-mapped privilege check ignores the effective mode. This only shows when `pc_lo` and `req_alt` select a non-kernel alternate mode while the current mode is kernel.

The vector table builds each of these from a chosen address and mode combination. The expected address is derived by hand from R6 and R12. Priority is probed with requests that break several rules at once, for example a misaligned, non-canonical, physical access.

// File: rtl/dxc_pkg.sv
// Shared definitions for the data access translation checker.
// Assumes a fault code of 3 bits and a 6-bit status vector.
package dxc_pkg;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ALIGN = 3'd1,
        FLT_PAGE  = 3'd2,
        FLT_ACV   = 3'd3,
        FLT_MISS  = 3'd4,
        FLT_DMISS = 3'd5,
        FLT_MCHK  = 3'd6,
        FLT_UNIMP = 3'd7
    } flt_e;

    localparam int ST_W     = 6;
    localparam int ST_WR    = 0;
    localparam int ST_BADVA = 1;
    localparam int ST_ACV   = 2;
    localparam int ST_MISS  = 3;
    localparam int ST_FOR   = 4;
    localparam int ST_FOW   = 5;

    localparam int          MODE_W      = 2;
    localparam int          NUM_MODES   = 1 << MODE_W;
    localparam logic [1:0]  MODE_KERNEL = 2'd0;

endpackage

// File: rtl/dxc_mode_sel.sv
// Effective mode selection for permission checks.
// Assumes kernel is encoded as mode zero.
module dxc_mode_sel
    import dxc_pkg::*;
(
    input  logic              pc_lo,
    input  logic              use_alt,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] alt_mode,
    output logic [MODE_W-1:0] eff_mode
);

    // Picks the mode from the PC low bit and the alternate-mode qualifier.
    always_comb begin
        if (pc_lo) eff_mode = use_alt ? alt_mode : MODE_KERNEL;
        else       eff_mode = cur_mode;
    end

endmodule

// File: rtl/dxc_check.sv
// Priority chain of address checks ahead of the physical-address rules.
// Produces a raw (possibly too wide) physical address when no fault is found.
// Assumes the lookup result belongs to the presented address.
module dxc_check
    import dxc_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int PA_W       = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int VA_IMPL_LO = 43,
    parameter int SP_HI      = 47,
    parameter int SP_LO      = 41,
    parameter int SP_TAG     = 'h7E,
    parameter int SX_BIT     = 40
) (
    input  logic                     [VA_W-1:0] va,
    input  logic                     [1:0]      size,
    input  logic                                write,
    input  logic                                phys,
    input  logic                                ptacc,
    input  logic                     [MODE_W-1:0] cur_mode,
    input  logic                     [MODE_W-1:0] eff_mode,
    input  logic                                tlb_hit,
    input  logic                     [PA_W-PAGE_SHIFT-1:0] tlb_ppn,
    input  logic                     [NUM_MODES-1:0] tlb_rd_en,
    input  logic                     [NUM_MODES-1:0] tlb_wr_en,
    input  logic                                tlb_for,
    input  logic                                tlb_fow,
    output flt_e                                fault,
    output logic                     [ST_W-1:0] stat,
    output logic                     [VA_W-1:0] pa_raw,
    output logic                                tlb_pass
);

    localparam int SP_W = SP_HI - SP_LO + 1;

    logic [2:0]            size_mask;
    logic                  misalign;
    logic                  canon;
    logic                  superpage;
    logic [PA_W-1:0]       sp_pa;
    logic [VA_W-1:0]       hit_pa;
    logic [VA_W-VA_IMPL_LO-1:0] upper;

    // Size mask and the simple address predicates.
    always_comb begin
        size_mask = 3'((4'd1 << size) - 4'd1);
        misalign  = |(va[2:0] & size_mask);
        upper     = va[VA_W-1:VA_IMPL_LO];
        canon     = (&upper) | ~(|upper);
        superpage = (va[SP_HI:SP_LO] == SP_W'(SP_TAG));
        hit_pa    = VA_W'({tlb_ppn, va[PAGE_SHIFT-1:0]});
    end

    // Direct-mapped address with top bits extended from the sign bit.
    always_comb begin
        sp_pa = va[PA_W-1:0];
        if (sp_pa[SX_BIT]) sp_pa[PA_W-1:SX_BIT] = '1;
        else               sp_pa[PA_W-1:SX_BIT] = '0;
    end

    // Ordered checks; the first failing check decides the fault.
    always_comb begin
        fault    = FLT_NONE;
        stat     = '0;
        pa_raw   = '0;
        tlb_pass = 1'b0;
        if (misalign) begin
            fault        = FLT_ALIGN;
            stat[ST_WR]  = write;
        end else if (phys) begin
            pa_raw = va;
        end else if (!canon) begin
            fault          = FLT_PAGE;
            stat[ST_WR]    = write;
            stat[ST_BADVA] = 1'b1;
            stat[ST_ACV]   = 1'b1;
        end else if (superpage) begin
            if (cur_mode != MODE_KERNEL) begin
                fault        = FLT_ACV;
                stat[ST_WR]  = write;
                stat[ST_ACV] = 1'b1;
            end else begin
                pa_raw = VA_W'(sp_pa);
            end
        end else if (!tlb_hit) begin
            fault         = ptacc ? FLT_DMISS : FLT_MISS;
            stat[ST_WR]   = write;
            stat[ST_MISS] = 1'b1;
        end else if (write) begin
            if (!tlb_wr_en[eff_mode]) begin
                fault        = FLT_PAGE;
                stat[ST_WR]  = 1'b1;
                stat[ST_ACV] = 1'b1;
                stat[ST_FOW] = tlb_fow;
            end else if (tlb_fow) begin
                fault        = FLT_PAGE;
                stat[ST_WR]  = 1'b1;
                stat[ST_FOW] = 1'b1;
            end else begin
                pa_raw   = hit_pa;
                tlb_pass = 1'b1;
            end
        end else begin
            if (!tlb_rd_en[eff_mode]) begin
                fault        = FLT_ACV;
                stat[ST_ACV] = 1'b1;
                stat[ST_FOR] = tlb_for;
            end else if (tlb_for) begin
                fault        = FLT_PAGE;
                stat[ST_FOR] = 1'b1;
            end else begin
                pa_raw   = hit_pa;
                tlb_pass = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dxc_pa_post.sv
// Physical-range and cacheability rules applied to a fault-free address.
// Assumes an earlier fault passes through unchanged with a zero address.
module dxc_pa_post
    import dxc_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int PA_W    = 44,
    parameter int CLR_HI  = 42,
    parameter int CLR_LO  = 35,
    parameter int WIN_LO  = 40,
    parameter int WIN_TAG = 'hA
) (
    input  flt_e               fault_in,
    input  logic [ST_W-1:0]    stat_in,
    input  logic [VA_W-1:0]    pa_raw,
    output flt_e               fault,
    output logic [ST_W-1:0]    stat,
    output logic [PA_W-1:0]    pa,
    output logic               uncached
);

    localparam int WIN_W = PA_W - WIN_LO;

    // Range check, register-window check, then the uncached address form.
    always_comb begin
        fault    = fault_in;
        stat     = stat_in;
        pa       = '0;
        uncached = 1'b0;
        if (fault_in == FLT_NONE) begin
            if (|pa_raw[VA_W-1:PA_W]) begin
                fault = FLT_MCHK;
            end else if (pa_raw[PA_W-1:WIN_LO] == WIN_W'(WIN_TAG)) begin
                fault = FLT_UNIMP;
            end else begin
                pa = pa_raw[PA_W-1:0];
                if (pa_raw[PA_W-1]) begin
                    uncached          = 1'b1;
                    pa[CLR_HI:CLR_LO] = '0;
                end
            end
        end
    end

endmodule

// File: rtl/dxc_counters.sv
// Wrapping event counters for hits, misses and violations.
// Assumes at most one event of each kind per cycle.
module dxc_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_hit,
    input  logic             inc_miss,
    input  logic             inc_viol,
    output logic [CNT_W-1:0] hit_q,
    output logic [CNT_W-1:0] miss_q,
    output logic [CNT_W-1:0] viol_q
);

    // Each counter steps by one on its event and wraps at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= '0;
            miss_q <= '0;
            viol_q <= '0;
        end else begin
            if (inc_hit)  hit_q  <= hit_q + 1'b1;
            if (inc_miss) miss_q <= miss_q + 1'b1;
            if (inc_viol) viol_q <= viol_q + 1'b1;
        end
    end

    p_hit_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        inc_hit |=> hit_q == $past(hit_q) + 1'b1);
    p_hit_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_hit |=> hit_q == $past(hit_q));
    p_miss_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_miss |=> miss_q == $past(miss_q));
    p_viol_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_viol |=> viol_q == $past(viol_q));

endmodule

// File: rtl/dxlate_check.sv
// Data access translation and protection checker, top level.
// Evaluates one request per cycle and registers the outcome.
// Assumes the external lookup result is valid alongside req_valid.
module dxlate_check
    import dxc_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int PA_W       = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int CNT_W      = 16,
    parameter int CLR_HI     = 42,
    parameter int CLR_LO     = 35
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [VA_W-1:0]             req_va,
    input  logic [1:0]                  req_size,
    input  logic                        req_write,
    input  logic                        req_phys,
    input  logic                        req_alt,
    input  logic                        req_ptacc,
    input  logic                        pc_lo,
    input  logic [1:0]                  cur_mode,
    input  logic [1:0]                  alt_mode,
    input  logic                        tlb_hit,
    input  logic [PA_W-PAGE_SHIFT-1:0]  tlb_ppn,
    input  logic [3:0]                  tlb_rd_en,
    input  logic [3:0]                  tlb_wr_en,
    input  logic                        tlb_for,
    input  logic                        tlb_fow,
    output logic                        rsp_valid,
    output logic [PA_W-1:0]             rsp_pa,
    output logic                        rsp_uncached,
    output logic [2:0]                  rsp_fault,
    output logic [5:0]                  rsp_stat,
    output logic [CNT_W-1:0]            hit_cnt,
    output logic [CNT_W-1:0]            miss_cnt,
    output logic [CNT_W-1:0]            viol_cnt
);

    logic [MODE_W-1:0] eff_mode;
    flt_e              chk_fault;
    logic [ST_W-1:0]   chk_stat;
    logic [VA_W-1:0]   pa_raw;
    logic              tlb_pass;
    flt_e              fin_fault;
    logic [ST_W-1:0]   fin_stat;
    logic [PA_W-1:0]   fin_pa;
    logic              fin_unc;
    flt_e              fault_q;
    logic              inc_miss;
    logic              inc_viol;

    dxc_mode_sel u_mode (
        .pc_lo    (pc_lo),
        .use_alt  (req_alt),
        .cur_mode (cur_mode),
        .alt_mode (alt_mode),
        .eff_mode (eff_mode)
    );

    dxc_check #(
        .VA_W       (VA_W),
        .PA_W       (PA_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_check (
        .va        (req_va),
        .size      (req_size),
        .write     (req_write),
        .phys      (req_phys),
        .ptacc     (req_ptacc),
        .cur_mode  (cur_mode),
        .eff_mode  (eff_mode),
        .tlb_hit   (tlb_hit),
        .tlb_ppn   (tlb_ppn),
        .tlb_rd_en (tlb_rd_en),
        .tlb_wr_en (tlb_wr_en),
        .tlb_for   (tlb_for),
        .tlb_fow   (tlb_fow),
        .fault     (chk_fault),
        .stat      (chk_stat),
        .pa_raw    (pa_raw),
        .tlb_pass  (tlb_pass)
    );

    dxc_pa_post #(
        .VA_W   (VA_W),
        .PA_W   (PA_W),
        .CLR_HI (CLR_HI),
        .CLR_LO (CLR_LO)
    ) u_post (
        .fault_in (chk_fault),
        .stat_in  (chk_stat),
        .pa_raw   (pa_raw),
        .fault    (fin_fault),
        .stat     (fin_stat),
        .pa       (fin_pa),
        .uncached (fin_unc)
    );

    // Classifies the final fault for the miss and violation counters.
    always_comb begin
        inc_miss = req_valid && (fin_fault == FLT_MISS || fin_fault == FLT_DMISS);
        inc_viol = req_valid && (fin_fault == FLT_PAGE || fin_fault == FLT_ACV);
    end

    dxc_counters #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_hit  (req_valid && tlb_pass),
        .inc_miss (inc_miss),
        .inc_viol (inc_viol),
        .hit_q    (hit_cnt),
        .miss_q   (miss_cnt),
        .viol_q   (viol_cnt)
    );

    // Output register: captures the outcome of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            fault_q      <= FLT_NONE;
            rsp_stat     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa       <= fin_pa;
                rsp_uncached <= fin_unc;
                fault_q      <= fin_fault;
                rsp_stat     <= fin_stat;
            end
        end
    end

    assign rsp_fault = fault_q;

    p_rsp_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_fault_pa_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> rsp_pa == '0);
    p_uncached_form_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_uncached) |-> (rsp_pa[PA_W-1] && rsp_pa[CLR_HI:CLR_LO] == '0));
    p_miss_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault == 3'd4 || rsp_fault == 3'd5)) |-> rsp_stat[3]);

endmodule

// File: tb/test_dxlate_check.sv
`timescale 1ns/1ps
module test_dxlate_check;

    typedef struct packed {
        logic [63:0] va;
        logic [1:0]  sz;
        logic        wr;
        logic        ph;
        logic        alt;
        logic        pt;
        logic        pcl;
        logic [1:0]  cm;
        logic [1:0]  am;
        logic        hit;
        logic [30:0] ppn;
        logic [3:0]  rd;
        logic [3:0]  we;
        logic        fr;
        logic        fw;
        logic [43:0] e_pa;
        logic        e_unc;
        logic [2:0]  e_flt;
        logic [5:0]  e_st;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [0:NV-1] = '{
        // R8 load hit, kernel
        '{64'h0000_0000_0012_3450, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 31'h1A2B, 4'hF, 4'hF, 1'b0, 1'b0, 44'h00003457450, 1'b0, 3'd0, 6'h00, 4'd8},
        // R2 misaligned store
        '{64'h0000_0000_0000_3452, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 31'h0, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 3'd1, 6'h01, 4'd2},
        // R2 alignment beats physical and canonical
        '{64'h0100_0000_0000_0001, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 31'h0, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 3'd1, 6'h00, 4'd2},
        // R5 non-canonical store
        '{64'h0000_1000_0000_0000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 31'h0, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 3'd2, 6'h07, 4'd5},
        // R4 physical pass-through, lookup reports miss
        '{64'h0000_0000_0ABC_DEF0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h0000ABCDEF0, 1'b0, 3'd0, 6'h00, 4'd4},
        // R11 physical out of range
        '{64'h0000_1000_0000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h0, 1'b0, 3'd6, 6'h00, 4'd11},
        // R12 uncached physical
        '{64'h0000_0812_3456_7890, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h80234567890, 1'b1, 3'd0, 6'h00, 4'd12},
        // R12 register window
        '{64'h0000_0A00_0000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h0, 1'b0, 3'd7, 6'h00, 4'd12},
        // R6 direct-mapped, bit 40 clear
        '{64'hFFFF_FC00_1234_5678, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h00012345678, 1'b0, 3'd0, 6'h00, 4'd6},
        // R6 direct-mapped, bit 40 set, then uncached form
        '{64'hFFFF_FD00_1234_5678, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h80012345678, 1'b1, 3'd0, 6'h00, 4'd6},
        // R6 direct-mapped store from user
        '{64'hFFFF_FC00_1234_5678, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h0, 1'b0, 3'd3, 6'h05, 4'd6},
        // R6 privilege uses current mode, not alternate
        '{64'hFFFF_FC00_1234_5678, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd3, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, 44'h00012345678, 1'b0, 3'd0, 6'h00, 4'd6},
        // R7 normal miss, load
        '{64'h0000_0000_0000_2000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 31'h0, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 3'd4, 6'h08, 4'd7},
        // R7 double miss, store
        '{64'h0000_0000_0000_2000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 31'h0, 4'hF, 4'hF, 1'b0, 1'b0, 44'h0, 1'b0, 3'd5, 6'h09, 4'd7},
        // R9 store denied for user, fault-on-write also set
        '{64'h0000_0000_0000_2000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 31'h1, 4'hF, 4'h7, 1'b0, 1'b1, 44'h0, 1'b0, 3'd2, 6'h25, 4'd9},
        // R9 store permitted with fault-on-write
        '{64'h0000_0000_0000_2000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 31'h1, 4'hF, 4'hF, 1'b0, 1'b1, 44'h0, 1'b0, 3'd2, 6'h21, 4'd9},
        // R10 load denied in alternate supervisor mode, fault-on-read set
        '{64'h0000_0000_0000_2000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd2, 1'b1, 31'h1, 4'hB, 4'hF, 1'b1, 1'b0, 44'h0, 1'b0, 3'd3, 6'h14, 4'd10},
        // R3 PC low bit without alternate flag means kernel
        '{64'h0000_0000_0000_2468, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd3, 1'b1, 31'h5, 4'h1, 4'h0, 1'b0, 1'b0, 44'h0000000A468, 1'b0, 3'd0, 6'h00, 4'd3},
        // R10 load permitted with fault-on-read
        '{64'h0000_0000_0000_2000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 31'h1, 4'hF, 4'hF, 1'b1, 1'b0, 44'h0, 1'b0, 3'd2, 6'h10, 4'd10},
        // R3 PC low bit clear uses current mode (user)
        '{64'h0000_0000_0000_2468, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 31'h5, 4'h1, 4'h0, 1'b0, 1'b0, 44'h0, 1'b0, 3'd3, 6'h04, 4'd3},
        // R12 translated address lands in uncached space
        '{64'h0000_0000_0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 31'h4000_0000, 4'hF, 4'hF, 1'b0, 1'b0, 44'h80000000000, 1'b1, 3'd0, 6'h00, 4'd12},
        // R9 permitted store in supervisor mode
        '{64'h0000_0000_0000_1FF8, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b1, 31'h7, 4'h0, 4'h4, 1'b0, 1'b0, 44'h0000000FFF8, 1'b0, 3'd0, 6'h00, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [63:0] req_va;
    logic [1:0]  req_size;
    logic        req_write, req_phys, req_alt, req_ptacc, pc_lo;
    logic [1:0]  cur_mode, alt_mode;
    logic        tlb_hit;
    logic [30:0] tlb_ppn;
    logic [3:0]  tlb_rd_en, tlb_wr_en;
    logic        tlb_for, tlb_fow;
    logic        rsp_valid, rsp_uncached;
    logic [43:0] rsp_pa;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_stat;
    logic [15:0] hit_cnt, miss_cnt, viol_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dxlate_check i_dxlate_check (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_va (req_va),
        .req_size (req_size), .req_write (req_write), .req_phys (req_phys),
        .req_alt (req_alt), .req_ptacc (req_ptacc), .pc_lo (pc_lo),
        .cur_mode (cur_mode), .alt_mode (alt_mode), .tlb_hit (tlb_hit),
        .tlb_ppn (tlb_ppn), .tlb_rd_en (tlb_rd_en), .tlb_wr_en (tlb_wr_en),
        .tlb_for (tlb_for), .tlb_fow (tlb_fow), .rsp_valid (rsp_valid),
        .rsp_pa (rsp_pa), .rsp_uncached (rsp_uncached), .rsp_fault (rsp_fault),
        .rsp_stat (rsp_stat), .hit_cnt (hit_cnt), .miss_cnt (miss_cnt),
        .viol_cnt (viol_cnt)
    );

    task automatic drive(input vec_t v);
        req_va = v.va; req_size = v.sz; req_write = v.wr; req_phys = v.ph;
        req_alt = v.alt; req_ptacc = v.pt; pc_lo = v.pcl; cur_mode = v.cm;
        alt_mode = v.am; tlb_hit = v.hit; tlb_ppn = v.ppn; tlb_rd_en = v.rd;
        tlb_wr_en = v.we; tlb_for = v.fr; tlb_fow = v.fw;
    endtask

    task automatic check_rsp(input vec_t v, input int idx);
        n_checks++;
        if (rsp_valid !== 1'b1 || rsp_pa !== v.e_pa || rsp_uncached !== v.e_unc ||
            rsp_fault !== v.e_flt || rsp_stat !== v.e_st) begin
            n_fail++;
            $display("FAIL R%0d vec %0d: v=%b pa=%h unc=%b flt=%0d st=%h, expected v=1 pa=%h unc=%b flt=%0d st=%h",
                     v.rq, idx, rsp_valid, rsp_pa, rsp_uncached, rsp_fault, rsp_stat,
                     v.e_pa, v.e_unc, v.e_flt, v.e_st);
        end
    endtask

    task automatic check_cnt(input string tag, input logic [15:0] h, input logic [15:0] m,
                             input logic [15:0] x);
        n_checks++;
        if (hit_cnt !== h || miss_cnt !== m || viol_cnt !== x) begin
            n_fail++;
            $display("FAIL %s: counters %0d/%0d/%0d, expected %0d/%0d/%0d",
                     tag, hit_cnt, miss_cnt, viol_cnt, h, m, x);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        // R1 reset state
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_pa !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: valid=%b pa=%h, expected 0 0", rsp_valid, rsp_pa);
        end
        check_cnt("R1 reset counters", 16'd0, 16'd0, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check_rsp(VECS[i], i);
        end

        // R13 counters after the table: 4 hits, 2 misses, 7 violations
        check_cnt("R13 table counters", 16'd4, 16'd2, 16'd7);

        // R1 idle cycle: no response, counters unchanged
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 idle: valid=%b, expected 0", rsp_valid);
        end
        check_cnt("R13 idle hold", 16'd4, 16'd2, 16'd7);

        // R1 back-to-back requests: hit then miss
        drive(VECS[0]);
        req_valid = 1'b1;
        @(negedge clk);
        drive(VECS[12]);
        check_rsp(VECS[0], 100);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(VECS[12], 101);
        check_cnt("R13 back-to-back", 16'd5, 16'd3, 16'd7);

        // R1 reset clears counters again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_cnt("R1 second reset", 16'd0, 16'd0, 16'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule